// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block runs one whole SMBus transaction over a byte-level I2C master engine. The engine handles bit timing, START/STOP generation and arbitration. The sequencer decides which byte goes out next and when to request START, STOP or a not-acknowledge. It takes a request made of a 7-bit target, a direction flag, a command byte, a transfer kind and a byte count. It then walks through its phases, paced by status events from the engine, and ends with a one-cycle `done` pulse carrying a result code.

Payload bytes live in a local byte buffer. The host fills it through a write port before a write transaction and reads it through a combinational read port after a read. Word transfers keep the low byte at index 0. Transfer kinds are encoded as 0 = quick, 1 = single byte, 2 = byte with command, 3 = word with command, 4 = block with command. Result codes are 0 = success, 1 = no device, 2 = I/O error, 3 = request rejected.

Top module: `smbus_seq`

## Requirements
- R1: For kinds 2, 3 and 4 the first byte sent is the 7-bit target shifted left by one with bit 0 = 0, and the second byte sent is the command byte.
- R2: After the command byte, a read request pulses `e_start` in the same cycle as `e_tx`, with `e_txd` = target shifted left by one and bit 0 = 1. Only one repeated START is issued per transaction.
- R3: After the command byte, a write request sends buffer entries 0, 1, … in ascending order, one per ready event: 1 byte for kind 2, 2 bytes for kind 3 (low byte at index 0), `req_len` bytes for kind 4.
- R4: Kinds 0 and 1 send no command phase. The first byte is the target shifted left by one with the direction flag in bit 0. A kind 1 write then sends `req_cmd` as its only data byte. A kind 1 read stores its byte at buffer index 0. A kind 0 write sends only the address.
- R5: During a read, `e_nack` is high when the engine delivers the final byte and low when it delivers any earlier byte. For a one-byte read it is armed together with the read address.
- R6: When the last read byte is taken, or when a write-phase ready event finds no bytes left, the block pulses `e_stop` and `done` together, returns to idle and reports result 0.
- R7: A negative acknowledge in any phase pulses `e_stop`, `e_clr` and `done` on the next cycle and reports result 1.
- R8: An event that comes with a bus error, or with `e_master` low, ends the transfer with result 2 and a `reset_req` pulse alongside `done`, and issues no STOP.
- R9: If no event arrives for `TMO` consecutive busy cycles, the transfer ends with result 2 and a `reset_req` pulse.
- R10: A kind 0 read, a block length of 0 or above `DEPTH`, or a kind above 4 is rejected. `done` is pulsed the next cycle with result 3, `busy` stays low and the engine sees no activity.
- R11: `req_go` is ignored while `busy` is high. The running transaction's byte sequence is unchanged.
- R12: After reset, `busy`, `done`, `reset_req`, `e_nack` and every engine pulse are low and `result` is 0.
- R13: Read bytes land in the buffer at indices 0, 1, … in arrival order and are visible through `hb_raddr`/`hb_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_go | input | 1 | Start-request strobe, sampled while idle |
| req_addr | input | 7 | Target address |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_cmd | input | 8 | Command byte (data byte for a kind 1 write) |
| req_kind | input | 3 | Transfer kind, 0..4 |
| req_len | input | $clog2(DEPTH+1) | Byte count for block kind |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Result code, held until the next completion |
| reset_req | output | 1 | Pulse asking for an engine reset |
| hb_we | input | 1 | Host buffer write enable |
| hb_waddr | input | $clog2(DEPTH) | Host buffer write index |
| hb_wdata | input | 8 | Host buffer write data |
| hb_raddr | input | $clog2(DEPTH) | Host buffer read index |
| hb_rdata | output | 8 | Host buffer read data |
| e_start | output | 1 | Pulse: engine issues (repeated) START |
| e_stop | output | 1 | Pulse: engine issues STOP |
| e_clr | output | 1 | Pulse: engine clears negative-ack and stall status |
| e_tx | output | 1 | Pulse: engine sends `e_txd` |
| e_txd | output | 8 | Byte to send |
| e_nack | output | 1 | Level: do not acknowledge the next received byte |
| e_rxd | input | 8 | Received byte, valid with `e_ready` in a read phase |
| e_ready | input | 1 | Event: engine ready for the next byte |
| e_buserr | input | 1 | Event: bus error |
| e_negack | input | 1 | Event: negative acknowledge |
| e_master | input | 1 | Level: engine holds the bus master role |

## Verification
The assertions assume that engine events are one-cycle pulses that arrive only while the block is busy. They also assume `e_master` is meaningful whenever an event is present. The bench's engine model respects this. It raises exactly one event at a time, two cycles after the previous one. It drops it on the following cycle, and stops as soon as `busy` falls. Error flags appear only together with an event slot. The bench pulses `req_go` only from idle, except for one deliberate pulse during a busy transfer.

// File: rtl/smbus_seq.sv
module smbus_seq #(
  parameter int DEPTH = 32,
  parameter int TMO = 1000,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(TMO + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_go,
  input  logic [6:0]    req_addr,
  input  logic          req_rd,
  input  logic [7:0]    req_cmd,
  input  logic [2:0]    req_kind,
  input  logic [LW-1:0] req_len,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic          reset_req,
  input  logic          hb_we,
  input  logic [AW-1:0] hb_waddr,
  input  logic [7:0]    hb_wdata,
  input  logic [AW-1:0] hb_raddr,
  output logic [7:0]    hb_rdata,
  output logic          e_start,
  output logic          e_stop,
  output logic          e_clr,
  output logic          e_tx,
  output logic [7:0]    e_txd,
  output logic          e_nack,
  input  logic [7:0]    e_rxd,
  input  logic          e_ready,
  input  logic          e_buserr,
  input  logic          e_negack,
  input  logic          e_master
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_REP, S_QUICK, S_READ, S_WRITE} st_t;
  localparam logic [1:0] RES_OK = 2'd0, RES_NODEV = 2'd1, RES_IOERR = 2'd2, RES_BAD = 2'd3;

  st_t           st;
  logic [7:0]    abyte, cmd_q;
  logic          byte_kind;
  logic [LW-1:0] rem, n;
  logic [AW-1:0] ptr;
  logic [TW-1:0] tmr;
  logic [7:0]    mem [DEPTH];
  logic          bad, ev, ev_ok, take;

  assign busy     = (st != S_IDLE);
  assign hb_rdata = mem[hb_raddr];
  assign ev       = e_ready | e_buserr | e_negack;
  assign ev_ok    = busy && ev && !e_buserr && e_master && !e_negack;
  assign take     = ev_ok && (st == S_READ);

  always_comb begin
    n   = '0;
    bad = 1'b0;
    case (req_kind)
      3'd0:       n = '0;
      3'd1, 3'd2: n = LW'(1);
      3'd3:       n = LW'(2);
      3'd4: begin
        n   = req_len;
        bad = (req_len == '0) || (req_len > LW'(DEPTH));
      end
      default:    bad = 1'b1;
    endcase
    if (req_rd && n == '0) bad = 1'b1;
  end

  always_ff @(posedge clk)
    if (take) mem[ptr] <= e_rxd;
    else if (hb_we) mem[hb_waddr] <= hb_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; result <= RES_OK; done <= 1'b0; reset_req <= 1'b0;
      e_start <= 1'b0; e_stop <= 1'b0; e_clr <= 1'b0; e_tx <= 1'b0;
      e_txd <= '0; e_nack <= 1'b0;
      abyte <= '0; cmd_q <= '0; byte_kind <= 1'b0; rem <= '0; ptr <= '0; tmr <= '0;
    end else begin
      done <= 1'b0; reset_req <= 1'b0;
      e_start <= 1'b0; e_stop <= 1'b0; e_clr <= 1'b0; e_tx <= 1'b0;
      if (st == S_IDLE) begin
        if (req_go) begin
          if (bad) begin
            done <= 1'b1; result <= RES_BAD;
          end else begin
            abyte <= {req_addr, req_rd}; cmd_q <= req_cmd;
            byte_kind <= (req_kind == 3'd1);
            rem <= n; ptr <= '0; tmr <= '0; e_nack <= 1'b0; e_start <= 1'b1;
            st <= (req_kind <= 3'd1) ? S_QUICK : S_ADDR;
          end
        end
      end else if (ev) begin
        tmr <= '0;
        if (e_buserr || !e_master) begin
          st <= S_IDLE; done <= 1'b1; result <= RES_IOERR; reset_req <= 1'b1;
        end else if (e_negack) begin
          st <= S_IDLE; done <= 1'b1; result <= RES_NODEV; e_stop <= 1'b1; e_clr <= 1'b1;
        end else begin
          case (st)
            S_ADDR: begin
              e_tx <= 1'b1; e_txd <= {abyte[7:1], 1'b0}; st <= S_CMD;
            end
            S_CMD: begin
              e_tx <= 1'b1; e_txd <= cmd_q; st <= abyte[0] ? S_REP : S_WRITE;
            end
            S_REP, S_QUICK: begin
              e_start <= (st == S_REP);
              e_tx <= 1'b1; e_txd <= abyte;
              if (abyte[0]) begin
                e_nack <= (rem == LW'(1)); st <= S_READ;
              end else st <= S_WRITE;
            end
            S_READ: begin
              e_nack <= (rem == LW'(2));
              ptr <= ptr + 1'b1; rem <= rem - 1'b1;
              if (rem == LW'(1)) begin
                st <= S_IDLE; done <= 1'b1; result <= RES_OK; e_stop <= 1'b1;
              end
            end
            S_WRITE: begin
              if (rem == '0) begin
                st <= S_IDLE; done <= 1'b1; result <= RES_OK; e_stop <= 1'b1;
              end else begin
                e_tx <= 1'b1; e_txd <= byte_kind ? cmd_q : mem[ptr];
                ptr <= ptr + 1'b1; rem <= rem - 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end else if (tmr == TW'(TMO - 1)) begin
        st <= S_IDLE; done <= 1'b1; result <= RES_IOERR; reset_req <= 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smbus_seq_chk.sv
module smbus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       reset_req,
  input logic       e_start,
  input logic       e_stop,
  input logic       e_clr,
  input logic       e_tx,
  input logic [7:0] e_txd,
  input logic       e_ready,
  input logic       e_buserr,
  input logic       e_negack,
  input logic       e_master
);
  a_r8_bus_error: assert property (@(posedge clk) disable iff (!rst_n)
    busy && e_buserr |=> done && result == 2'd2 && reset_req && !e_stop);

  a_r8_lost_master: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (e_ready || e_negack) && !e_buserr && !e_master |=> done && result == 2'd2 && reset_req);

  a_r7_negack: assert property (@(posedge clk) disable iff (!rst_n)
    busy && e_negack && !e_buserr && e_master |=> done && result == 2'd1 && e_stop && e_clr && !busy);

  a_r6_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    e_stop |-> done && !busy);

  a_r2_rep_read: assert property (@(posedge clk) disable iff (!rst_n)
    e_start && e_tx |-> e_txd[0]);

  a_r9_reset_err: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> done && result == 2'd2);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r3_tx_busy: assert property (@(posedge clk) disable iff (!rst_n)
    e_tx |-> busy);
endmodule

bind smbus_seq smbus_seq_chk chk (.*);

// File: tb/tb_smbus_seq.sv
module tb_smbus_seq;
  localparam int DEPTH = 32, TMO = 1000, AW = 5, LW = 6;

  logic clk = 0, rst_n = 0;
  logic req_go = 0, req_rd = 0;
  logic [6:0] req_addr = 0;
  logic [7:0] req_cmd = 0;
  logic [2:0] req_kind = 0;
  logic [LW-1:0] req_len = 0;
  logic busy, done, reset_req, e_start, e_stop, e_clr, e_tx, e_nack;
  logic [1:0] result;
  logic hb_we = 0;
  logic [AW-1:0] hb_waddr = 0, hb_raddr = 0;
  logic [7:0] hb_wdata = 0, hb_rdata, e_txd, e_rxd = 0;
  logic e_ready = 0, e_buserr = 0, e_negack = 0, e_master = 1;

  smbus_seq dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errs = 0;
  int tx_n, starts, stops, clrs, dones, last_res, last_rst;
  logic [7:0] tx_log [64];
  logic nack_log [64];

  always @(negedge clk) begin
    if (e_tx) begin tx_log[tx_n[5:0]] = e_txd; tx_n++; end
    if (e_start) starts++;
    if (e_stop) stops++;
    if (e_clr) clrs++;
    if (done) begin dones++; last_res = result; last_rst = reset_req; end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [7:0] wpat(input int i); return 8'(i * 13 + 7); endfunction
  function automatic logic [7:0] rpat(input int k); return 8'h5A ^ 8'(k * 37); endfunction

  task automatic clear_logs();
    tx_n = 0; starts = 0; stops = 0; clrs = 0; dones = 0; last_res = -1; last_rst = 0;
  endtask

  // err_kind: 0 none, 1 negack, 2 bus error, 3 lost master, 4 silence (timeout)
  task automatic run(input int kind, input bit rd, input int len, input int err_kind,
                     input int err_at, input bit poke);
    logic [6:0] a;
    logic [7:0] c;
    logic [7:0] exp_tx [64];
    int en, n, first, k;
    bit has_cmd;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); hb_we = 1; hb_waddr = AW'(i); hb_wdata = wpat(i);
    end
    @(negedge clk); hb_we = 0;
    a = 7'(7'h11 + kind * 9 + len);
    c = 8'hC3 ^ 8'(len);
    clear_logs();
    req_go = 1; req_addr = a; req_rd = rd; req_cmd = c; req_kind = 3'(kind); req_len = LW'(len);
    @(negedge clk); req_go = 0;
    k = 0;
    while (busy) begin
      repeat (2) @(negedge clk);
      if (!busy) break;
      if (poke && k == 1) begin
        req_go = 1; req_kind = 3'd0; req_rd = 0; req_addr = 7'h7F;
        @(negedge clk); req_go = 0;
      end
      if (err_kind == 4 && k == err_at) begin
        repeat (TMO - 5) @(negedge clk);
        chk(busy == 1, "R9 still busy before timeout", busy, 1);
        while (busy) @(negedge clk);
        break;
      end
      e_rxd = rpat(k);
      nack_log[k[5:0]] = e_nack;
      if (err_at == k && err_kind == 1) e_negack = 1;
      else if (err_at == k && err_kind == 2) e_buserr = 1;
      else if (err_at == k && err_kind == 3) begin e_master = 0; e_ready = 1; end
      else e_ready = 1;
      @(negedge clk);
      e_ready = 0; e_negack = 0; e_buserr = 0; e_master = 1;
      k++;
    end
    @(negedge clk);
    chk(dones == 1, "R6 one done pulse", dones, 1);
    if (err_kind == 1) begin
      chk(last_res == 1, "R7 negack result", last_res, 1);
      chk(stops == 1 && clrs == 1, "R7 stop and clear", stops * 10 + clrs, 11);
      return;
    end
    if (err_kind >= 2) begin
      chk(last_res == 2, "R8/R9 io error result", last_res, 2);
      chk(last_rst == 1, "R8/R9 reset request", last_rst, 1);
      chk(stops == 0, "R8/R9 no stop", stops, 0);
      return;
    end
    has_cmd = kind >= 2;
    n = (kind == 0) ? 0 : (kind <= 2) ? 1 : (kind == 3) ? 2 : len;
    en = 0;
    if (has_cmd) begin
      exp_tx[en++] = {a, 1'b0};
      exp_tx[en++] = c;
      if (rd) exp_tx[en++] = {a, 1'b1};
      else for (int i = 0; i < n; i++) exp_tx[en++] = wpat(i);
    end else begin
      exp_tx[en++] = {a, rd};
      if (!rd && kind == 1) exp_tx[en++] = c;
    end
    chk(last_res == 0, "R6 success result", last_res, 0);
    chk(stops == 1, "R6 single stop", stops, 1);
    chk(starts == 1 + int'(has_cmd && rd), "R2 start count", starts, 1 + int'(has_cmd && rd));
    chk(tx_n == en, "R1/R3/R4 byte count", tx_n, en);
    for (int i = 0; i < en && i < tx_n; i++)
      chk(tx_log[i] == exp_tx[i], $sformatf("R1/R2/R3/R4/R11 kind%0d rd%0d byte%0d", kind, rd, i),
          tx_log[i], exp_tx[i]);
    if (rd) begin
      first = has_cmd ? 3 : 1;
      for (int j = 0; j < n; j++) begin
        chk(nack_log[6'(first + j)] == (j == n - 1), $sformatf("R5 nack byte%0d of %0d", j, n),
            nack_log[6'(first + j)], int'(j == n - 1));
        hb_raddr = AW'(j); #1;
        chk(hb_rdata == rpat(first + j), $sformatf("R13 read byte%0d", j), hb_rdata, rpat(first + j));
      end
    end
  endtask

  task automatic reject(input int kind, input bit rd, input int len);
    clear_logs();
    @(negedge clk);
    req_go = 1; req_kind = 3'(kind); req_rd = rd; req_len = LW'(len);
    @(negedge clk); req_go = 0;
    chk(done == 1 && result == 2'd3, $sformatf("R10 reject kind%0d len%0d", kind, len), result, 3);
    chk(busy == 0, "R10 stays idle", busy, 0);
    @(negedge clk);
    chk(tx_n == 0 && starts == 0, "R10 no engine activity", tx_n + starts, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !reset_req && !e_nack && !e_start && !e_stop && !e_tx && !e_clr,
        "R12 reset outputs", busy, 0);
    chk(result == 0, "R12 reset result", result, 0);
    run(0, 0, 0, 0, 0, 0);
    for (int kd = 1; kd <= 3; kd++)
      for (int r = 0; r < 2; r++) run(kd, r[0], 0, 0, 0, 0);
    for (int l = 1; l <= DEPTH; l++)
      for (int r = 0; r < 2; r++) run(4, r[0], l, 0, 0, 0);
    run(4, 0, 3, 0, 0, 1);   // R11 request while busy
    for (int e = 0; e < 4; e++) run(2, 0, 0, 1, e, 0);
    run(4, 1, 3, 1, 4, 0);
    run(3, 1, 0, 2, 1, 0);
    run(2, 0, 0, 3, 2, 0);
    run(4, 1, 4, 4, 3, 0);
    run(0, 0, 0, 4, 0, 0);
    reject(0, 1, 0);
    reject(4, 0, 0);
    reject(4, 1, 33);
    reject(5, 0, 1);
    reject(7, 1, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule